// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop Controller

This block sits between a set of free-running source clocks and the clock output pins of a clock generator. Each output has its own enable bit in a control register. A set bit lets the clock through. A clear bit parks the output low. The enable is brought into each clock's own domain on that clock's falling edge, and the gate only ever changes while the source is low. Because of this, every high pulse that reaches a pin has its full width, both when an output starts and when it stops.

One pin has two uses, chosen by a configuration bit. With the bit clear, the pin is an open-drain reset output. The block pulls it low while the oscillator settle interval runs and releases it once the interval has completed. With the bit set, the pin is an active-low power-down input. Driving it low stops every output. When it is released, the settle interval runs again before any enabled output is let through. The settle interval is a cycle counter on the system clock, and its length is a parameter. All outputs stay low until it completes, both after reset and after power-down.

There is no data stream in this block, so it has no valid/ready interface. All control and status pins are plain levels.

Top module: `clkstop_ctrl`

## Requirements
- R1: Once the settle interval has completed and no power-down is active, output `clk_out[i]` toggles exactly when `out_en[i]` is 1.
- R2: An output whose enable bit is 0 stays at logic 0 and shows no rising edge.
- R3: Every high pulse on `clk_out[i]` is as wide as the high phase of `src_clk[i]`, including the first pulse after a start and the last pulse before a stop.
- R4: With `pin_mode` = 0 (reset-output function, the value after reset), `rst_drive_low` is 1 during reset and while the settle interval runs, and 0 once it has completed. With `pin_mode` = 1, `rst_drive_low` is 0.
- R5: With `pin_mode` = 1 and `pd_pin_n` = 0, `pwrdn_active` is 1 and every output is parked low.
- R6: With `pin_mode` = 0, the level on `pd_pin_n` has no effect: `pwrdn_active` stays 0 and the enabled outputs keep running.
- R7: After reset, all outputs stay low until `SETTLE_CYCLES` system-clock cycles have been counted.
- R8: When power-down ends, the settle counter starts again from zero, and every output stays low until it completes.
- R9: The gate enable of an output changes only while that output's source clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the settle counter and the power-down synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | N_OUT | Free-running source clocks, one per output |
| out_en | input | N_OUT | Per-output enable bits from the control register (1 = run) |
| pin_mode | input | 1 | Function of the shared pin: 0 = reset output, 1 = power-down input |
| pd_pin_n | input | 1 | Shared pin sensed as an active-low power-down request (asynchronous) |
| clk_out | output | N_OUT | Gated clock outputs, parked low when stopped |
| pwrdn_active | output | 1 | 1 while a power-down request is in effect |
| rst_drive_low | output | 1 | Open-drain enable for the shared pin: 1 = pull the pin low |

## Verification
The gating is exercised with all outputs enabled, with alternating enable patterns, and with all outputs disabled. Each output runs at a different period, so a wrongly routed enable shows up as the wrong output running. The pattern sets are repeated in both pin modes, with the power-down pin driven low and driven high. This separates a true power-down from a pin level that must be ignored in the reset-output mode. Every high pulse is timed against its source's half period for the whole run, so any truncated start or stop pulse is caught. Separate directed steps sample the outputs partway through the settle interval, both after reset and after power-down ends, to confirm that nothing is released early.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    PIN_RESET_OUT = 1'b0,
    PIN_PWRDN_IN  = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/cs_bit_sync.sv
module cs_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cs_settle_timer.sv
module cs_settle_timer #(
  parameter int CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (hold)           cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);

  // R8: a power-down hold clears the settle state on the next cycle
  assert_hold_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !done);
  // R7: completion is reached only from the last count value
  assert_done_after_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt_q) == LIMIT - 1'b1);
  // R7: once complete, the timer stays complete until a hold arrives
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hold) |=> done);
endmodule

// File: rtl/cs_gate_cell.sv
module cs_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_out
);
  logic [SYNC_STAGES-1:0] en_sync_q;
  logic                   gate_en;

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en_sync_q <= '0;
    else        en_sync_q <= {en_sync_q[SYNC_STAGES-2:0], run_req};
  end

  assign gate_en = en_sync_q[SYNC_STAGES-1];
  assign clk_out = src_clk & gate_en;

  // R9: the gate may only open or close while the source is low
  always @(gate_en) begin
    if (rst_n) begin
      assert_gate_moves_low_R9: assert (!src_clk);
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int N_OUT         = 4,
  parameter int SETTLE_CYCLES = 125000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] src_clk,
  input  logic [N_OUT-1:0] out_en,
  input  logic             pin_mode,
  input  logic             pd_pin_n,
  output logic [N_OUT-1:0] clk_out,
  output logic             pwrdn_active,
  output logic             rst_drive_low
);
  import cs_pkg::*;

  pin_mode_e        mode;
  logic             pd_n_s;
  logic             settled;
  logic             run;
  logic [N_OUT-1:0] req_q;

  assign mode = pin_mode_e'(pin_mode);

  cs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(sys_clk), .rst_n(rst_n), .d(pd_pin_n), .q(pd_n_s)
  );

  assign pwrdn_active = (mode == PIN_PWRDN_IN) && !pd_n_s;

  cs_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(sys_clk), .rst_n(rst_n), .hold(pwrdn_active), .done(settled)
  );

  assign run           = settled && !pwrdn_active;
  assign rst_drive_low = (mode == PIN_RESET_OUT) && !settled;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= run ? out_en : '0;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    cs_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .src_clk(src_clk[g]), .rst_n(rst_n), .run_req(req_q[g]), .clk_out(clk_out[g])
    );
  end

  // R7: no output is requested while settling
  assert_park_while_settling_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !settled |=> req_q == '0);
  // R5: a power-down withdraws every request
  assert_pwrdn_parks_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    pwrdn_active |=> req_q == '0);
  // R4: the reset pull is never active in the power-down-input function
  assert_no_pull_in_pd_mode_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (pin_mode && $stable(pin_mode)) |-> !rst_drive_low);
endmodule

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
  localparam int N      = 4;
  localparam int SETTLE = 32;
  localparam int NV     = 9;
  localparam real HALF_NS [N] = '{5.0, 7.0, 3.0, 4.5};

  logic sys_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic [N-1:0] src_clk;
  logic [N-1:0] out_en   = '1;
  logic         pin_mode = 1'b0;
  logic         pd_pin_n = 1'b1;
  logic [N-1:0] clk_out;
  logic         pwrdn_active, rst_drive_low;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 sys_clk = ~sys_clk;

  clkstop_ctrl #(.N_OUT(N), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) dut_i (
    .sys_clk(sys_clk), .rst_n(rst_n), .src_clk(src_clk), .out_en(out_en),
    .pin_mode(pin_mode), .pd_pin_n(pd_pin_n), .clk_out(clk_out),
    .pwrdn_active(pwrdn_active), .rst_drive_low(rst_drive_low)
  );

  int  rises  [N];
  int  pulses [N];
  int  bad_cnt[N];
  real bad_w  [N];

  for (genvar g = 0; g < N; g++) begin : g_src
    real t_rise;
    bit  seen;
    initial begin
      src_clk[g] = 1'b0; rises[g] = 0; pulses[g] = 0; bad_cnt[g] = 0; bad_w[g] = 0.0;
      seen = 0;
    end
    always #(HALF_NS[g]) src_clk[g] = ~src_clk[g];
    always @(posedge clk_out[g]) begin
      rises[g] = rises[g] + 1; t_rise = $realtime; seen = 1;
    end
    always @(negedge clk_out[g]) begin
      if (seen) begin
        real w;
        w = $realtime - t_rise;
        pulses[g] = pulses[g] + 1;
        if (w < HALF_NS[g] - 0.001 || w > HALF_NS[g] + 0.001) begin
          bad_cnt[g] = bad_cnt[g] + 1; bad_w[g] = w;
        end
      end
    end
  end

  // Vector table: enable bits, pin mode, pd pin level, expected running mask, expected pwrdn
  localparam logic [N-1:0] V_EN   [NV] = '{4'b1111, 4'b0101, 4'b1010, 4'b0000, 4'b1111,
                                           4'b1111, 4'b0110, 4'b1001, 4'b1001};
  localparam logic         V_MODE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic         V_PDN  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [N-1:0] V_RUN  [NV] = '{4'b1111, 4'b0101, 4'b1010, 4'b0000, 4'b1111,
                                           4'b0000, 4'b0110, 4'b0000, 4'b1001};
  localparam logic         V_PD   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Observe for a number of system cycles: which outputs rose, which were ever high
  task automatic observe(input int cycles, output logic [N-1:0] ran, output logic [N-1:0] high);
    int snap[N];
    for (int i = 0; i < N; i++) snap[i] = rises[i];
    high = '0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge sys_clk);
      high |= clk_out;
    end
    for (int i = 0; i < N; i++) ran[i] = (rises[i] != snap[i]);
  endtask

  task automatic wait_sys(input int n);
    for (int c = 0; c < n; c++) @(negedge sys_clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ran, high;
    // Reset state (R4, R7)
    wait_sys(5);
    check(clk_out == '0, "R7", "outputs in reset", int'(clk_out), 0);
    check(rst_drive_low == 1'b1, "R4", "reset pull in reset", int'(rst_drive_low), 1);
    check(pwrdn_active == 1'b0, "R5", "pwrdn in reset", int'(pwrdn_active), 0);
    rst_n = 1'b1;
    // Mid-settle after reset (R7, R4)
    observe(SETTLE / 2, ran, high);
    check(high == '0, "R7", "outputs during settle", int'(high), 0);
    check(rst_drive_low == 1'b1, "R4", "reset pull during settle", int'(rst_drive_low), 1);
    wait_sys(SETTLE);
    check(rst_drive_low == 1'b0, "R4", "reset pull after settle", int'(rst_drive_low), 0);

    // Table walk (R1, R2, R5, R6)
    for (int v = 0; v < NV; v++) begin
      out_en = V_EN[v]; pin_mode = V_MODE[v]; pd_pin_n = V_PDN[v];
      wait_sys(SETTLE + 20);
      observe(40, ran, high);
      check(ran == V_RUN[v], (V_MODE[v] && !V_PDN[v]) ? "R5" : "R1",
            $sformatf("running mask vec %0d", v), int'(ran), int'(V_RUN[v]));
      check((high & ~V_RUN[v]) == '0, "R2", $sformatf("stopped held low vec %0d", v),
            int'(high & ~V_RUN[v]), 0);
      check(pwrdn_active == V_PD[v], V_MODE[v] ? "R5" : "R6",
            $sformatf("pwrdn vec %0d", v), int'(pwrdn_active), int'(V_PD[v]));
      check(rst_drive_low == 1'b0, "R4", $sformatf("no pull vec %0d", v), int'(rst_drive_low), 0);
    end

    // Leaving power-down reruns the settle interval (R8), no pull in pd-input mode (R4)
    out_en = '1; pin_mode = 1'b1; pd_pin_n = 1'b0;
    wait_sys(20);
    pd_pin_n = 1'b1;
    wait_sys(4);
    observe(SETTLE / 2, ran, high);
    check(high == '0, "R8", "outputs during re-settle", int'(high), 0);
    check(rst_drive_low == 1'b0, "R4", "no pull in pd-input mode", int'(rst_drive_low), 0);
    wait_sys(SETTLE);
    observe(40, ran, high);
    check(ran == '1, "R8", "outputs after re-settle", int'(ran), 15);

    // Pulse widths over the whole run (R3, R9)
    for (int i = 0; i < N; i++) begin
      check(pulses[i] > 0, "R3", $sformatf("pulses seen out %0d", i), pulses[i], 1);
      check(bad_cnt[i] == 0, "R3",
            $sformatf("short pulses out %0d (last width ps %0d)", i, int'(bad_w[i] * 1000.0)),
            bad_cnt[i], 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule